// File: doc/BRIEF.md
# Chained Packet Stream Engine

This engine moves data from memory to a device by following a chain of packets stored in memory. Each packet opens with one header word. The header's upper byte holds the number of payload words that follow it. Its low 24 bits hold the address of the next header. A single pulse on `start_i` together with a byte address launches the walk. From then on the engine reads one word at a time through a request/valid memory port and forwards each payload word to the device through a valid/ready port. It keeps going until it reaches a header whose next-pointer field has its top bit set. That packet's payload is still sent, and then `done_o` pulses for one cycle.

The controller is an explicit state machine with six states:
- `ST_IDLE` waits for a start.
- `ST_HDR` fetches a header.
- `ST_PAYREQ` fetches one payload word.
- `ST_PUSH` offers that word to the device.
- `ST_LINK` tests the end marker or jumps to the next header.
- `ST_FINISH` raises the done pulse.

The transitions are:
- `ST_IDLE -> ST_HDR` on start.
- `ST_HDR -> ST_PAYREQ` on a header with a non-zero count.
- `ST_HDR -> ST_LINK` on a header with a zero count.
- `ST_PAYREQ -> ST_PUSH` when the memory data arrives.
- `ST_PUSH -> ST_PAYREQ` when the device accepts and words remain.
- `ST_PUSH -> ST_LINK` when the device accepts the last word.
- `ST_LINK -> ST_FINISH` on the end marker.
- `ST_LINK -> ST_HDR` otherwise.
- `ST_FINISH -> ST_IDLE` unconditionally.

Top module: `ll_walker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mem_req_o`, `dev_valid_o` and `done_o` are low.
- R2: The first memory read after an accepted start uses `start_addr_i` with bits 1:0 forced to zero. Every address presented on `mem_addr_o` is word aligned.
- R3: A header word is decoded as follows: bits 31:24 are the payload word count (0..255) and bits 23:0 are the next-pointer field.
- R4: The payload words of a packet are read from the addresses that follow the header in ascending 4-byte steps. They are delivered to the device in read order, each exactly once.
- R5: A header with a count of zero produces no device write. The engine proceeds directly to the end-marker check.
- R6: After a packet, bit 23 of its next-pointer field set ends the chain. Otherwise the next header is read at the next-pointer field with bits 1:0 cleared.
- R7: Address stepping wraps modulo 2^24. The word after address 0xFFFFFC is read at 0x000000.
- R8: Once `dev_valid_o` is high, it and `dev_data_o` hold unchanged until `dev_ready_i` is seen high.
- R9: At most one memory read is outstanding. While `mem_req_o` is high without `mem_valid_i`, the request and `mem_addr_o` stay unchanged, and `mem_rdata_i` is taken only in the cycle `mem_valid_i` is high.
- R10: `done_o` is high for exactly one cycle per chain. It rises two cycles after the final completing handshake: the last payload acceptance, or the header read when the terminating packet is empty.
- R11: A start pulse arriving while a chain is being walked has no effect on reads, device writes or the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start request, accepted only when idle |
| start_addr_i | input | 24 | Byte address of the first header |
| mem_req_o | output | 1 | Memory read request, held until `mem_valid_i` |
| mem_addr_o | output | 24 | Word-aligned byte address of the read |
| mem_valid_i | input | 1 | Read data valid, completes the current read |
| mem_rdata_i | input | 32 | Read data |
| dev_valid_o | output | 1 | Payload word offered to the device |
| dev_data_o | output | 32 | Payload word |
| dev_ready_i | input | 1 | Device accepts the offered word |
| done_o | output | 1 | One-cycle pulse at the end of a chain |

## Verification
A wrong internal state surfaces at the ports within one or two cycles:
- A miscounted remaining-word register, or a bad header decode, puts a wrong address on `mem_addr_o` in the cycle the next read is requested. It also shows as an extra or missing device word.
- A lost end marker produces a header read where none is expected. A premature one moves `done_o` off its two-cycle slot.
- A wrongly stepped or masked address register is visible on the very next request.

The reference model therefore checks the request address, the offered device word and the done level in every clock, under varied memory latency and device back-pressure.

// File: rtl/ll_walker_pkg.sv
`timescale 1ns/1ps
package ll_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAYREQ,
        ST_PUSH,
        ST_LINK,
        ST_FINISH
    } walk_state_t;

    typedef struct packed {
        logic mem_req;
        logic dev_valid;
        logic done;
        logic addr_load_start;
        logic addr_load_next;
        logic addr_step;
        logic hdr_capture;
        logic cnt_load;
        logic cnt_dec;
        logic data_capture;
    } walk_ctrl_t;

endpackage

// File: rtl/ll_hdr_decode.sv
`timescale 1ns/1ps
module ll_hdr_decode #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              count_zero_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic              last_o
);
    localparam int CNT_LSB = DATA_W - CNT_W;

    always_comb begin
        count_o      = word_i[CNT_LSB +: CNT_W];
        count_zero_o = (count_o == '0);
        next_addr_o  = {word_i[ADDR_W-1:2], 2'b00};
        last_o       = word_i[ADDR_W-1];
    end
endmodule

// File: rtl/ll_addr_unit.sv
`timescale 1ns/1ps
module ll_addr_unit #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              load_next_i,
    input  logic [ADDR_W-1:0] next_addr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_addr_o
);
    localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load_start_i) begin
            cur_q <= start_addr_i & ALIGN_MASK;
        end else if (load_next_i) begin
            cur_q <= next_addr_i & ALIGN_MASK;
        end else if (step_i) begin
            cur_q <= cur_q + WORD_STEP;
        end
    end

    assign cur_addr_o = cur_q;
endmodule

// File: rtl/ll_beat_counter.sv
`timescale 1ns/1ps
module ll_beat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dec_i,
    output logic             empty_o
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= count_i;
        end else if (dec_i && (left_q != '0)) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign empty_o = (left_q == '0);
endmodule

// File: rtl/ll_walker_fsm.sv
`timescale 1ns/1ps
module ll_walker_fsm
    import ll_walker_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mem_valid_i,
    input  logic       dev_ready_i,
    input  logic       hdr_count_zero_i,
    input  logic       beats_empty_i,
    input  logic       link_last_i,
    output walk_ctrl_t ctrl_o
);
    walk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)     state_d = ST_HDR;
            ST_HDR:    if (mem_valid_i) state_d = hdr_count_zero_i ? ST_LINK : ST_PAYREQ;
            ST_PAYREQ: if (mem_valid_i) state_d = ST_PUSH;
            ST_PUSH:   if (dev_ready_i) state_d = beats_empty_i ? ST_LINK : ST_PAYREQ;
            ST_LINK:   state_d = link_last_i ? ST_FINISH : ST_HDR;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                ctrl_o.addr_load_start = start_i;
            end
            ST_HDR: begin
                ctrl_o.mem_req     = 1'b1;
                ctrl_o.hdr_capture = mem_valid_i;
                ctrl_o.cnt_load    = mem_valid_i;
                ctrl_o.addr_step   = mem_valid_i;
            end
            ST_PAYREQ: begin
                ctrl_o.mem_req      = 1'b1;
                ctrl_o.data_capture = mem_valid_i;
                ctrl_o.cnt_dec      = mem_valid_i;
                ctrl_o.addr_step    = mem_valid_i;
            end
            ST_PUSH: begin
                ctrl_o.dev_valid = 1'b1;
            end
            ST_LINK: begin
                ctrl_o.addr_load_next = !link_last_i;
            end
            ST_FINISH: begin
                ctrl_o.done = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/ll_walker.sv
`timescale 1ns/1ps
module ll_walker
    import ll_walker_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              dev_valid_o,
    output logic [DATA_W-1:0] dev_data_o,
    input  logic              dev_ready_i,
    output logic              done_o
);
    walk_ctrl_t        ctrl;
    logic [CNT_W-1:0]  hdr_count;
    logic              hdr_count_zero;
    logic [ADDR_W-1:0] hdr_next;
    logic              hdr_last;
    logic [ADDR_W-1:0] link_next_q;
    logic              link_last_q;
    logic [DATA_W-1:0] data_q;
    logic              beats_empty;
    logic [ADDR_W-1:0] cur_addr;

    ll_hdr_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .word_i       (mem_rdata_i),
        .count_o      (hdr_count),
        .count_zero_o (hdr_count_zero),
        .next_addr_o  (hdr_next),
        .last_o       (hdr_last)
    );

    ll_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_start_i (ctrl.addr_load_start),
        .start_addr_i (start_addr_i),
        .load_next_i  (ctrl.addr_load_next),
        .next_addr_i  (link_next_q),
        .step_i       (ctrl.addr_step),
        .cur_addr_o   (cur_addr)
    );

    ll_beat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ctrl.cnt_load),
        .count_i (hdr_count),
        .dec_i   (ctrl.cnt_dec),
        .empty_o (beats_empty)
    );

    ll_walker_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .mem_valid_i      (mem_valid_i),
        .dev_ready_i      (dev_ready_i),
        .hdr_count_zero_i (hdr_count_zero),
        .beats_empty_i    (beats_empty),
        .link_last_i      (link_last_q),
        .ctrl_o           (ctrl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_next_q <= '0;
            link_last_q <= 1'b0;
        end else if (ctrl.hdr_capture) begin
            link_next_q <= hdr_next;
            link_last_q <= hdr_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (ctrl.data_capture) begin
            data_q <= mem_rdata_i;
        end
    end

    assign mem_req_o   = ctrl.mem_req;
    assign mem_addr_o  = cur_addr;
    assign dev_valid_o = ctrl.dev_valid;
    assign dev_data_o  = data_q;
    assign done_o      = ctrl.done;
endmodule

// File: rtl/ll_walker_chk.sv
`timescale 1ns/1ps
module ll_walker_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_valid_i,
    input logic              dev_valid_o,
    input logic [DATA_W-1:0] dev_data_o,
    input logic              dev_ready_i,
    input logic              done_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R9

    AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid_o && !dev_ready_i) |=> (dev_valid_o && $stable(dev_data_o))); // R8

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mem_req_o && !dev_valid_o)); // R10

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && dev_valid_o)); // R9
endmodule

bind ll_walker ll_walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .dev_valid_o (dev_valid_o),
    .dev_data_o  (dev_data_o),
    .dev_ready_i (dev_ready_i),
    .done_o      (done_o)
);

// File: tb/ll_walker_test.sv
`timescale 1ns/1ps
module ll_walker_test;
    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_valid_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          dev_valid_o;
    logic [DW-1:0] dev_data_o;
    logic          dev_ready_i = 1'b0;
    logic          done_o;

    always #2.5 clk = ~clk;

    ll_walker uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
        .mem_rdata_i(mem_rdata_i), .dev_valid_o(dev_valid_o), .dev_data_o(dev_data_o),
        .dev_ready_i(dev_ready_i), .done_o(done_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] mem [int];
    logic [AW-1:0] exp_addr[$];
    logic [DW-1:0] exp_dev[$];
    bit    term_on_hdr = 1'b0;
    int    done_due = 0;
    int    done_cnt = 0;
    int    lat_cfg = 0;
    int    wait_cnt = 0;
    bit    ready_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    string tag = "reset";

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%h expected=%h", what, tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {8'h5A ^ a[7:0], a};
    endfunction

    function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return pat(a);
    endfunction

    function automatic logic [DW-1:0] hdr(input int cnt, input logic [AW-1:0] nxt);
        logic [7:0] c = cnt[7:0];
        return {c, nxt};
    endfunction

    // Behavioural walk of the chain held in mem: expected reads and device words.
    task automatic build(input logic [AW-1:0] s);
        logic [AW-1:0] a;
        logic [DW-1:0] h;
        int c;
        a = s & 24'hFFFFFC;
        exp_addr.delete();
        exp_dev.delete();
        for (int g = 0; g < 64; g++) begin
            exp_addr.push_back(a);
            h = rd(a);
            c = int'(h[31:24]);
            a = a + 24'd4;
            for (int i = 0; i < c; i++) begin
                exp_addr.push_back(a);
                exp_dev.push_back(rd(a));
                a = a + 24'd4;
            end
            if (h[23]) begin
                term_on_hdr = (c == 0);
                break;
            end
            a = h[23:0] & 24'hFFFFFC;
        end
    endtask

    // Per-clock reference comparison and input drive, away from the active edge.
    always @(negedge clk) begin
        bit exp_done;
        if (!rst_n) begin
            mem_valid_i = 1'b0;
            dev_ready_i = 1'b0;
            wait_cnt = 0;
        end else begin
            exp_done = (done_due == 1);
            if (done_due > 0) done_due--;
            chk(done_o === exp_done, "R10 R11 done level", 32'(done_o), 32'(exp_done));
            if (done_o) done_cnt++;

            if (mem_req_o) begin
                if (exp_addr.size() == 0)
                    chk(1'b0, "R6 R11 unexpected read", 32'(mem_addr_o), 32'hFFFFFFFF);
                else
                    chk(mem_addr_o === exp_addr[0], "R2 R4 R6 R7 R9 read address",
                        32'(mem_addr_o), 32'(exp_addr[0]));
                mem_valid_i = (wait_cnt >= lat_cfg);
                mem_rdata_i = rd(mem_addr_o);
                if (mem_valid_i) begin
                    wait_cnt = 0;
                    if (exp_addr.size() > 0) begin
                        void'(exp_addr.pop_front());
                        if (term_on_hdr && exp_addr.size() == 0) done_due = 2;
                    end
                end else begin
                    wait_cnt++;
                end
            end else begin
                mem_valid_i = 1'b0;
                wait_cnt = 0;
            end

            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dev_ready_i = ready_rand ? lfsr[0] : 1'b1;
            if (dev_valid_o) begin
                if (exp_dev.size() == 0)
                    chk(1'b0, "R5 R11 unexpected device word", dev_data_o, 32'hFFFFFFFF);
                else
                    chk(dev_data_o === exp_dev[0], "R3 R4 R8 device word", dev_data_o, exp_dev[0]);
                if (dev_ready_i && exp_dev.size() > 0) begin
                    void'(exp_dev.pop_front());
                    if (!term_on_hdr && exp_dev.size() == 0) done_due = 2;
                end
            end
        end
    end

    task automatic run_chain(input logic [AW-1:0] s, input int lat, input bit rr,
                             input string t, input int inject);
        int prev;
        tag = t;
        lat_cfg = lat;
        ready_rand = rr;
        build(s);
        prev = done_cnt;
        @(negedge clk);
        start_i = 1'b1;
        start_addr_i = s;
        @(negedge clk);
        start_i = 1'b0;
        if (inject > 0) begin
            repeat (inject) @(negedge clk);
            start_i = 1'b1;
            start_addr_i = 24'h000100;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == prev) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_addr.size() == 0, "R4 R6 reads outstanding", 32'(exp_addr.size()), 32'd0);
        chk(exp_dev.size() == 0, "R4 device words outstanding", 32'(exp_dev.size()), 32'd0);
        chk(done_cnt == prev + 1, "R10 R11 done count", 32'(done_cnt - prev), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired [%s] actual=running expected=finished", tag);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        chk(!mem_req_o && !dev_valid_o && !done_o, "R1 reset outputs",
            {29'd0, mem_req_o, dev_valid_o, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !dev_valid_o && !done_o, "R1 after reset outputs",
            {29'd0, mem_req_o, dev_valid_o, done_o}, 32'd0);

        // R2 R3 R4: unaligned start, one packet of three words, end marker
        mem[32'h000100] = hdr(3, 24'h800000);
        run_chain(24'h000103, 0, 1'b0, "single packet", 0);

        // R5 R6 R8: three packets, middle empty, masked next pointer, back-pressure
        mem[32'h001000] = hdr(2, 24'h002003);
        mem[32'h002000] = hdr(0, 24'h003000);
        mem[32'h003000] = hdr(4, 24'hFFFFFF);
        run_chain(24'h001000, 2, 1'b1, "three packets", 0);

        // R5 R10: lone empty terminator
        mem[32'h004000] = hdr(0, 24'h800000);
        run_chain(24'h004000, 1, 1'b0, "empty terminator", 0);

        // R7: payload crossing the top of the address range
        mem[32'hFFFFF8] = hdr(3, 24'h800000);
        run_chain(24'hFFFFF8, 3, 1'b1, "address wrap", 0);

        // R10: payloads then empty terminating packet with other bits in the pointer
        mem[32'h005000] = hdr(2, 24'h006000);
        mem[32'h006000] = hdr(0, 24'h8ABCDE);
        run_chain(24'h005000, 0, 1'b1, "empty tail", 0);

        // R11: start pulse while busy
        mem[32'h007000] = hdr(20, 24'h800000);
        run_chain(24'h007000, 1, 1'b1, "start while busy", 10);

        // R4: maximum count
        mem[32'h008000] = hdr(255, 24'h800000);
        run_chain(24'h008000, 0, 1'b0, "max count", 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule